// File: doc/BRIEF.md
# Staged Right Rotator and Shifter

This block moves an N-bit data word to the right by a binary distance, either rotating it or shifting it with a zero or sign fill. The movement is built from a chain of log2(N) fixed-distance stages. Stage k moves the word by 2^k places when bit k of the distance input is set and passes it through otherwise, so the total movement is the sum of the enabled stage distances. An 8-bit word uses three stages of 1, 2 and 4 places, which is 24 two-input selectors.

A 2-bit mode input picks the operation. Code 00 rotates: bits that leave the low end come back in at the high end. Code 01 is a logical shift that fills the vacated upper places with zeros. Code 10 is an arithmetic shift that fills them with copies of the most significant bit of the input word. Code 11 behaves as a rotate.

The result goes through one output register, so it appears on the rising clock edge after the inputs are presented. The register is cleared by a synchronous active-low reset. The width must be a power of two of at least 2, and the distance input is log2(N) bits wide.

Top module: `barrel_rotshift`

## Requirements
- R1: While rst_n is low at a rising clock edge, y_out becomes all zeros on that edge.
- R2: When the distance is zero, y_out after the next edge equals the data word in every mode.
- R3: With mode 00 and distance d, y_out bit i equals input bit (i+d) mod N, so bits leaving the low end re-enter at the high end.
- R4: With mode 01 and distance d, y_out is the input shifted right by d with the top d bits set to 0.
- R5: With mode 10 and distance d, y_out is the input shifted right by d with the top d bits equal to input bit N-1. For example, 8'b1000_0000 moved by 1 gives 8'b1100_0000.
- R6: Mode 11 gives the same result as mode 00.
- R7: The total movement equals the sum of the stage distances 2^k for the set bits k of the distance, across the whole range 0 to N-1.
- R8: y_out changes only at a rising clock edge and reflects the inputs sampled on that edge, which is a latency of one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the output register captures on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| x_in | input | WIDTH | Data word to be moved |
| amt_in | input | log2(WIDTH) | Distance to move right, in bit places |
| mode_in | input | 2 | 00 rotate, 01 logical shift, 10 arithmetic shift, 11 rotate |
| y_out | output | WIDTH | Registered result |

## Verification
The hardest cases are those in which two or three stages are enabled at once on a word whose top bit is set. In the arithmetic mode, the fill seen by the later stages must still be the original sign bit and not whatever bits the earlier stages moved into the top. The bench runs an exhaustive sweep of all 256 data words against all eight distances and all four mode codes at 8 bits, so every combination of stages meets every sign and wrap pattern. Each result is compared with values computed arithmetically in the bench, and mode 11 is checked against the rotate formula.

// File: rtl/rotshift_pkg.sv
// Package rotshift_pkg
// Holds the mode encoding shared by the staged rotator and its checker.
// Assumes a 2-bit mode field. Code 11 is decoded as a rotate.
package rotshift_pkg;

    typedef enum logic [1:0] {
        MODE_ROT     = 2'b00,
        MODE_LSR     = 2'b01,
        MODE_ASR     = 2'b10,
        MODE_ROT_ALT = 2'b11
    } rs_mode_e;

endpackage

// File: rtl/rotshift_mode_dec.sv
// Module rotshift_mode_dec
// Turns the 2-bit mode and the input sign bit into two controls:
//   wrap: the stages rotate instead of shifting.
//   fill: the bit that shift stages insert at the top.
// Assumes the sign bit is the most significant bit of the unmodified input word.
module rotshift_mode_dec
    import rotshift_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       sign_bit,
    output logic       wrap,
    output logic       fill
);

    // Decode the mode into the wrap and fill controls.
    always_comb begin
        wrap = 1'b0;
        fill = 1'b0;
        case (rs_mode_e'(mode))
            MODE_ROT, MODE_ROT_ALT: wrap = 1'b1;
            MODE_LSR:               fill = 1'b0;
            MODE_ASR:               fill = sign_bit;
            default:                wrap = 1'b1;
        endcase
    end

endmodule

// File: rtl/rotshift_stage.sv
// Module rotshift_stage
// One fixed-distance stage of the chain.
// When en is set it moves the word right by DIST places. With wrap set, the bits
// that leave the low end re-enter at the top; otherwise the top DIST places take fill.
// When en is clear the word passes through unchanged.
// Assumes 0 < DIST < W.
module rotshift_stage #(
    parameter int W    = 8,
    parameter int DIST = 1
) (
    input  logic [W-1:0] d_in,
    input  logic         en,
    input  logic         wrap,
    input  logic         fill,
    output logic [W-1:0] d_out
);

    logic [DIST-1:0] top_bits;

    // Pick the bits that enter the top positions: the wrapped low bits or the fill.
    always_comb begin
        top_bits = wrap ? d_in[DIST-1:0] : {DIST{fill}};
    end

    // Apply the move, or pass the word through.
    always_comb begin
        d_out = en ? {top_bits, d_in[W-1:DIST]} : d_in;
    end

endmodule

// File: rtl/rotshift_oreg.sv
// Module rotshift_oreg
// The output register. It clears on a synchronous active-low reset and
// otherwise loads the stage chain's result on every rising edge.
module rotshift_oreg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    // Capture the result, or clear it while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/barrel_rotshift.sv
// Module barrel_rotshift
// A right rotator and shifter built as log2(WIDTH) cascaded stages.
// Stage k moves the word by 2^k places when amt_in[k] is set. The result is
// registered once, so the latency is one clock.
// Assumes WIDTH is a power of two and at least 2.
module barrel_rotshift #(
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] x_in,
    input  logic [AW-1:0]    amt_in,
    input  logic [1:0]       mode_in,
    output logic [WIDTH-1:0] y_out
);

    logic             wrap;
    logic             fill;
    logic [WIDTH-1:0] chain [0:AW];

    // Derive the wrap and fill controls from the mode and the original sign bit.
    rotshift_mode_dec u_dec (
        .mode     (mode_in),
        .sign_bit (x_in[WIDTH-1]),
        .wrap     (wrap),
        .fill     (fill)
    );

    // Feed the data word into the head of the chain.
    always_comb begin
        chain[0] = x_in;
    end

    // One stage per distance bit, each moving the word by a power of two.
    for (genvar k = 0; k < AW; k++) begin : g_stage
        rotshift_stage #(
            .W    (WIDTH),
            .DIST (1 << k)
        ) u_stage (
            .d_in  (chain[k]),
            .en    (amt_in[k]),
            .wrap  (wrap),
            .fill  (fill),
            .d_out (chain[k+1])
        );
    end

    // Register the result of the last stage.
    rotshift_oreg #(.W(WIDTH)) u_oreg (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (chain[AW]),
        .q     (y_out)
    );

endmodule

// File: rtl/barrel_rotshift_chk.sv
// Module barrel_rotshift_chk
// Checks the port behaviour of barrel_rotshift over time. It is attached to the
// top module by the bind statement at the end of this file.
module barrel_rotshift_chk #(
    parameter int WIDTH = 8,
    localparam int AW   = $clog2(WIDTH)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] x_in,
    input logic [AW-1:0]    amt_in,
    input logic [1:0]       mode_in,
    input logic [WIDTH-1:0] y_out
);

    // Set once a reset edge has been seen, so the R1 check never looks at values from before the first clock.
    logic seen_rst;
    always_ff @(posedge clk) begin
        if (!rst_n) seen_rst <= 1'b1;
    end

    // R1: a reset edge leaves the output at zero.
    always @(negedge clk) begin
        if (seen_rst === 1'b1 && rst_n === 1'b0) begin
            assert_reset_clear_R1: assert (y_out == '0);
        end
    end

    // R2: a distance of zero passes the data word through.
    assert_zero_amount_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (amt_in == '0) |=> (y_out == $past(x_in)));

    // R3: a rotate only rearranges the bits, so the count of ones is preserved.
    assert_rotate_keeps_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b00) |=> ($countones(y_out) == $countones($past(x_in))));

    // R4: a logical shift by a nonzero distance clears the top bit.
    assert_logical_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b01 && amt_in != '0) |=> (y_out[WIDTH-1] == 1'b0));

    // R5: an arithmetic shift keeps the original sign bit.
    assert_arith_sign_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b10) |=> (y_out[WIDTH-1] == $past(x_in[WIDTH-1])));

    // R6: mode 11 rotates, so it also preserves the count of ones.
    assert_alt_rotate_ones_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_in == 2'b11) |=> ($countones(y_out) == $countones($past(x_in))));

    // R8: the output holds at any edge where the inputs and reset did not change.
    assert_output_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(x_in) && $stable(amt_in) && $stable(mode_in) && $past(rst_n))
        |=> $stable(y_out));

endmodule

bind barrel_rotshift barrel_rotshift_chk #(.WIDTH(WIDTH)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .x_in    (x_in),
    .amt_in  (amt_in),
    .mode_in (mode_in),
    .y_out   (y_out)
);

// File: tb/tb_barrel_rotshift.sv
module tb_barrel_rotshift;

    localparam int W  = 8;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  x_in = '0;
    logic [AW-1:0] amt_in = '0;
    logic [1:0]    mode_in = '0;
    logic [W-1:0]  y_out;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #10 clk = ~clk;

    barrel_rotshift #(.WIDTH(W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .x_in    (x_in),
        .amt_in  (amt_in),
        .mode_in (mode_in),
        .y_out   (y_out)
    );

    // Compute the expected result arithmetically from the requirements.
    function automatic logic [W-1:0] ref_fn(input logic [W-1:0] x, input int a, input logic [1:0] m);
        logic [2*W-1:0]      dbl;
        logic signed [W-1:0] sx;
        dbl = {x, x} >> a;
        sx  = $signed(x);
        case (m)
            2'b01:   return x >> a;
            2'b10:   return W'(sx >>> a);
            default: return dbl[W-1:0];
        endcase
    endfunction

    // Compare one value, count it and report a failure.
    task automatic check(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: y_out=%b expected=%b (x=%b amt=%0d mode=%b)",
                     req, got, exp, x_in, amt_in, mode_in);
        end
    endtask

    // Drive the inputs on a falling edge and check the output on the next falling edge.
    task automatic apply(input logic [W-1:0] x, input int a, input logic [1:0] m, input string req);
        @(negedge clk);
        x_in = x; amt_in = AW'(a); mode_in = m;
        @(negedge clk);
        check(req, y_out, ref_fn(x, a, m));
    endtask

    // Name the requirement that a given mode and distance exercise.
    function automatic string tag(input int a, input logic [1:0] m);
        if (a == 0) return "R2";
        case (m)
            2'b00:   return "R3/R7";
            2'b01:   return "R4/R7";
            2'b10:   return "R5/R7";
            default: return "R6";
        endcase
    endfunction

    initial begin
        // R1: the output register clears while reset is held, even with live inputs.
        x_in = 8'hA5; amt_in = 3'd3; mode_in = 2'b01;
        repeat (3) @(negedge clk);
        check("R1", y_out, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // R5: arithmetic shift examples with a negative word.
        apply(8'b1000_0000, 1, 2'b10, "R5");
        check("R5", y_out, 8'b1100_0000);
        apply(8'b1001_0010, 3, 2'b10, "R5");
        check("R5", y_out, 8'b1111_0010);
        // R4: a logical shift of the same word fills with zeros.
        apply(8'b1001_0010, 3, 2'b01, "R4");
        check("R4", y_out, 8'b0001_0010);
        // R3: a rotate by 1 moves the low bit to the top.
        apply(8'b0000_0001, 1, 2'b00, "R3");
        check("R3", y_out, 8'b1000_0000);
        // R7: a distance of 7 uses all three stages.
        apply(8'b1000_0000, 7, 2'b00, "R7");
        check("R7", y_out, 8'b0000_0001);

        // R8: new inputs have no effect until the next rising edge.
        @(negedge clk);
        x_in = 8'h0F; amt_in = 3'd2; mode_in = 2'b00;
        #2 check("R8", y_out, 8'b0000_0001);
        @(negedge clk);
        check("R8", y_out, 8'hC3);

        // Exhaustive sweep: every data word, distance and mode code.
        for (int x = 0; x < 256; x++) begin
            for (int m = 0; m < 4; m++) begin
                for (int a = 0; a < W; a++) begin
                    apply(W'(x), a, 2'(m), tag(a, 2'(m)));
                end
            end
        end

        // R6: mode 11 matches the mode 00 result for the same word.
        apply(8'h96, 5, 2'b11, "R6");
        check("R6", y_out, ref_fn(8'h96, 5, 2'b00));

        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Watchdog: a run that hangs counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: y_out=%b expected=run complete", y_out);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule